// File: doc/BRIEF.md
# Dual-Rail Power-Good Reset Supervisor

This block decides when downstream logic may leave reset. For each regulated rail it takes two flags: a comparator flag that says the feedback voltage is above 90% of nominal, and a flag that says the rail's soft-start ramp has finished. It also takes the undervoltage-lockout and over-temperature fault flags and a millisecond tick. Its output is a pull-low enable for an open-drain reset pin, plus a status bit that reads high while the pin is released.

The release timer counts millisecond ticks only while the block is qualified. Qualified means every rail is above threshold, every ramp is complete and no fault is present. When any of these conditions is lost, the pull-low enable is asserted in the same cycle and the timer is cleared. The full delay must then run again after the conditions recover. The comparator flags are used as they arrive, with no hysteresis and no filtering.

Top module: `rail_reset_supervisor`

## Requirements
- R1: `rst_pull_o` is 1 (pin driven low) in every cycle in which any bit of `fb_ok_i` is 0. The change is combinational, in that same cycle.
- R2: The timer does not advance while any bit of `ramp_done_i` is 0. The pin stays pulled low however many ticks arrive.
- R3: With the block qualified (all `fb_ok_i` bits 1, all `ramp_done_i` bits 1, `uvlo_i`=0, `overtemp_i`=0), `rst_pull_o` falls to 0 right after the clock edge that samples the `TIMEOUT_MS`-th `ms_tick_i` pulse counted since qualification began. It never falls earlier.
- R4: There is no hysteresis. A dip of one rail flag lasting a single cycle re-asserts `rst_pull_o` in that cycle, even after release.
- R5: `uvlo_i`=1 or `overtemp_i`=1 forces `rst_pull_o` to 1 and stops release.
- R6: Any loss of qualification clears the count to zero. After recovery, a full `TIMEOUT_MS` ticks are needed again.
- R7: While `rst_ni` is low, and after it rises, `rst_pull_o` is 1 and `rails_good_o` is 0 until the first qualified timeout completes.
- R8: The pin is open-drain. `rst_pull_o`=1 means pull low and 0 means high impedance; the block never drives the pin high. `rails_good_o` is always the inverse of `rst_pull_o`.
- R9: Once released, the pin stays released for as long as qualification holds, with any number of further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fb_ok_i | input | NUM_RAILS | Per-rail flag: feedback above 90% of nominal |
| ramp_done_i | input | NUM_RAILS | Per-rail soft-start complete |
| uvlo_i | input | 1 | Undervoltage lockout active |
| overtemp_i | input | 1 | Thermal shutdown active |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| rst_pull_o | output | 1 | Enable for the open-drain pull-down on the reset pin |
| rails_good_o | output | 1 | Status: reset pin released |

## Verification
The bench builds the block with `NUM_RAILS`=2 and `TIMEOUT_MS`=6, and pulses the tick every third cycle. At these values the whole release delay, the saturated hold after it, and restarts that happen part-way through a count all fit in a few dozen cycles. This exposes off-by-one errors at the expiry edge. Single-cycle dips and fault pulses are placed both before and after release, so both instant re-assertion and the full restart of the count are observed.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef struct packed {
    logic fb_all;
    logic ramp_all;
    logic fault;
  } qual_t;
endpackage

// File: rtl/rsup_qualify.sv
module rsup_qualify
  import rsup_pkg::*;
#(
  parameter int NUM_RAILS = 2
) (
  input  logic [NUM_RAILS-1:0] fb_ok_i,
  input  logic [NUM_RAILS-1:0] ramp_done_i,
  input  logic                 uvlo_i,
  input  logic                 overtemp_i,
  output qual_t                flags_o,
  output logic                 qualified_o
);
  logic [NUM_RAILS-1:0] rail_ready;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    assign rail_ready[g] = fb_ok_i[g] & ramp_done_i[g];
  end

  assign flags_o.fb_all   = &fb_ok_i;
  assign flags_o.ramp_all = &ramp_done_i;
  assign flags_o.fault    = uvlo_i | overtemp_i;
  assign qualified_o      = (&rail_ready) & ~flags_o.fault;
endmodule

// File: rtl/rsup_timer.sv
module rsup_timer #(
  parameter int TIMEOUT_MS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qualified_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam int CW = $clog2(TIMEOUT_MS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_MS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!qualified_i)                cnt_q <= '0;
    else if (tick_i && (cnt_q != LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIMIT);

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qualified_i |=> (cnt_q == '0)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT); // R9
  AST_CNT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qualified_i && !tick_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/rsup_drive.sv
module rsup_drive (
  input  logic qualified_i,
  input  logic expired_i,
  output logic pull_en_o,
  output logic good_o
);
  logic release_c;

  // release only while still qualified: any dip pulls low in the same cycle
  assign release_c = qualified_i & expired_i;
  assign pull_en_o = ~release_c;
  assign good_o    = release_c;
endmodule

// File: rtl/rail_reset_supervisor.sv
module rail_reset_supervisor
  import rsup_pkg::*;
#(
  parameter int NUM_RAILS  = 2,
  parameter int TIMEOUT_MS = 200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_RAILS-1:0] fb_ok_i,
  input  logic [NUM_RAILS-1:0] ramp_done_i,
  input  logic                 uvlo_i,
  input  logic                 overtemp_i,
  input  logic                 ms_tick_i,
  output logic                 rst_pull_o,
  output logic                 rails_good_o
);
  qual_t flags;
  logic  qualified;
  logic  expired;
  logic  pull_en;

  rsup_qualify #(.NUM_RAILS(NUM_RAILS)) i_qualify (
    .fb_ok_i     (fb_ok_i),
    .ramp_done_i (ramp_done_i),
    .uvlo_i      (uvlo_i),
    .overtemp_i  (overtemp_i),
    .flags_o     (flags),
    .qualified_o (qualified)
  );

  rsup_timer #(.TIMEOUT_MS(TIMEOUT_MS)) i_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .qualified_i (qualified),
    .tick_i      (ms_tick_i),
    .expired_o   (expired)
  );

  rsup_drive i_drive (
    .qualified_i (qualified),
    .expired_i   (expired),
    .pull_en_o   (pull_en),
    .good_o      (rails_good_o)
  );

  assign rst_pull_o = pull_en;

  AST_FB_LOW_PULLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags.fb_all |-> rst_pull_o); // R1
  AST_RAMP_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flags.ramp_all |-> rst_pull_o); // R2
  AST_FAULT_PULLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags.fault |-> rst_pull_o); // R5
  AST_RELEASE_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_pull_o) |-> expired); // R3
  AST_STATUS_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rails_good_o != rst_pull_o); // R8
endmodule

// File: tb/test_rail_reset_supervisor.sv
module test_rail_reset_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int T = 6;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] fb_ok = '0;
  logic [1:0] ramp_done = '0;
  logic       uvlo = 1'b1;
  logic       overtemp = 1'b0;
  logic       tick = 1'b0;
  logic       rst_pull;
  logic       rails_good;

  int n_checks = 0;
  int n_fail = 0;
  int mcnt = 0;
  int cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_reset_supervisor #(.NUM_RAILS(2), .TIMEOUT_MS(T)) i_rail_reset_supervisor (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .fb_ok_i      (fb_ok),
    .ramp_done_i  (ramp_done),
    .uvlo_i       (uvlo),
    .overtemp_i   (overtemp),
    .ms_tick_i    (tick),
    .rst_pull_o   (rst_pull),
    .rails_good_o (rails_good)
  );

  task automatic check(input logic exp_pull, input string req);
    n_checks++;
    if (rst_pull !== exp_pull || rails_good !== ~exp_pull) begin
      n_fail++;
      $display("FAIL %s cyc=%0d: pull=%b good=%b expected pull=%b good=%b",
               req, cyc, rst_pull, rails_good, exp_pull, ~exp_pull);
    end
  endtask

  // one cycle: drive at negedge, compare against model, advance model at posedge
  task automatic step(input logic [1:0] fb, input logic [1:0] rd,
                      input logic uv, input logic ot, input string req);
    bit q;
    @(negedge clk);
    fb_ok = fb; ramp_done = rd; uvlo = uv; overtemp = ot;
    tick = (cyc % 3 == 2);
    #1;
    q = (fb == 2'b11) && (rd == 2'b11) && !uv && !ot;
    check(!(q && mcnt == T), req);
    @(posedge clk);
    if (!q) mcnt = 0;
    else if (tick && mcnt < T) mcnt++;
    cyc++;
  endtask

  task automatic run(input int n, input logic [1:0] fb, input logic [1:0] rd,
                     input logic uv, input logic ot, input string req);
    for (int i = 0; i < n; i++) step(fb, rd, uv, ot, req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
  end

  initial begin
    // R7: reset state
    repeat (2) @(negedge clk);
    #1 check(1'b1, "R7 in reset");
    @(negedge clk);
    rst_ni = 1'b1;
    run(4, 2'b00, 2'b00, 1'b1, 1'b0, "R7 after reset, uvlo");
    // R2: rails up, second ramp pending
    run(30, 2'b11, 2'b01, 1'b0, 1'b0, "R2 ramp pending");
    // R3 / R8: qualified through full timeout
    run(3 * T + 4, 2'b11, 2'b11, 1'b0, 1'b0, "R3 R8 release timing");
    // R9: stays released
    run(15, 2'b11, 2'b11, 1'b0, 1'b0, "R9 hold released");
    // R4 / R1: single-cycle dip of rail 1 after release
    step(2'b01, 2'b11, 1'b0, 1'b0, "R4 R1 single-cycle dip");
    // R6: full delay again
    run(3 * T + 4, 2'b11, 2'b11, 1'b0, 1'b0, "R6 restart after dip");
    // R1: rail 0 low for several cycles
    run(5, 2'b10, 2'b11, 1'b0, 1'b0, "R1 rail0 low");
    // R6: partial count then loss, then full count again
    run(3 * (T - 2), 2'b11, 2'b11, 1'b0, 1'b0, "R6 partial count");
    step(2'b11, 2'b10, 1'b0, 1'b0, "R6 ramp loss mid-count");
    run(3 * T + 4, 2'b11, 2'b11, 1'b0, 1'b0, "R6 full count after partial");
    // R5: faults
    run(3, 2'b11, 2'b11, 1'b1, 1'b0, "R5 uvlo");
    run(3 * T + 2, 2'b11, 2'b11, 1'b0, 1'b0, "R5 recover after uvlo");
    run(4, 2'b11, 2'b11, 1'b0, 1'b1, "R5 overtemp");
    run(3 * (T + 1), 2'b11, 2'b11, 1'b0, 1'b1, "R5 overtemp with ticks");
    run(3 * T + 4, 2'b11, 2'b11, 1'b0, 1'b0, "R5 recover after overtemp");
    summary();
  end
endmodule